// File: doc/BRIEF.md
# Cascadable Four-Bit Carry Chain

This block is a segment-based carry chain for wide add and subtract. Each segment handles exactly four bit positions. At every bit a carry-select multiplexer either forwards the incoming carry or substitutes a local generate bit. An XOR gate then forms the sum from the propagate bit and the incoming carry. Per bit, a segment takes a propagate signal and a generate/data signal, as lookup logic would supply them. It returns four sum bits, the carry leaving each bit, and a final carry-out.

Segments are stacked so that each carry-out drives the carry-in of the next segment up. A column of segments therefore forms one long chain. The top module stacks a parameterised number of segments into an adder/subtractor:

- propagate is `op_a XOR b_eff`;
- generate is `op_a`;
- `b_eff` is `op_b`, inverted when `invert_b` is set;
- the first segment's carry-in is `carry_init`.

Driving `invert_b = 1` and `carry_init = 1` gives two's-complement subtraction.

Top module: `carry_column`

## Requirements
- R1: At each bit the carry leaving the bit equals the incoming carry when propagate is 1, and equals the generate bit (`op_a` bit) when propagate is 0.
- R2: Each result bit equals that bit's propagate value XOR the carry entering that bit.
- R3: `seg_carry[k]` is the carry leaving segment k, where segment k covers bits 4k+3..4k. It equals bit 4(k+1) of `op_a[4k+3:0] + b_eff[4k+3:0] + carry_init`, and it is the carry-in of segment k+1.
- R4: With `invert_b = 0`, `{carry_out, result}` equals `op_a + op_b + carry_init`, evaluated in W+1 bits.
- R5: With `invert_b = 1` and `carry_init = 1`, `result` equals `op_a - op_b` modulo 2^W. In this mode `carry_out` is 1 exactly when `op_a >= op_b` (unsigned), meaning no borrow.
- R6: `overflow` is 1 exactly when `op_a` and `b_eff` have the same sign bit (bit W-1) and `result` has a different sign bit.
- R7: When every bit propagates (`op_a XOR b_eff` all ones), the initial carry passes the whole column unchanged. All `seg_carry` bits and `carry_out` then equal `carry_init`.
- R8: When no bit propagates (`op_a == b_eff`), `carry_out` equals `op_a[W-1]` regardless of `carry_init`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W = 4*SEGS | First operand; also the generate input of every bit |
| op_b | input | W | Second operand |
| invert_b | input | 1 | 1 inverts `op_b` before it enters the chain |
| carry_init | input | 1 | Carry-in of the lowest segment |
| result | output | W | Sum bits of the whole column |
| carry_out | output | 1 | Carry-out of the top segment |
| overflow | output | 1 | Signed overflow of the operation |
| seg_carry | output | SEGS | Carry-out of each segment, lowest segment in bit 0 |

## Verification
The bench builds the column with the default `SEGS = 4`, which gives a 16-bit word. That size puts segment boundaries at bits 3, 7, 11 and 15. Carries can then be observed crossing each boundary, and signed overflow can be observed at the top of the word. Random operands are mixed with directed corner cases: a full ripple from bit 0 to the top, all-propagate and no-propagate words, and subtraction with equal, smaller and larger subtrahends.

// File: rtl/carry4_seg.sv
module carry4_seg (
  input  logic       ci,
  input  logic [3:0] prop,
  input  logic [3:0] gen,
  output logic [3:0] sum,
  output logic [3:0] carry,
  output logic       co
);
  localparam int N = 4;

  logic [N:0] c;
  assign c[0] = ci;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign c[i+1] = prop[i] ? c[i] : gen[i];
    assign sum[i] = prop[i] ^ c[i];
  end

  assign carry = c[N:1];
  assign co    = c[N];

  always_comb begin
    if (&prop) begin
      AST_PASS_THROUGH: assert (co == ci && sum == {N{~ci}})  // R1
        else $error("segment pass-through broken");
    end
    if (prop == '0) begin
      AST_NO_PROPAGATE: assert (co == gen[N-1] && sum == {carry[N-2:0], ci})  // R2
        else $error("segment kill behaviour broken");
    end
  end
endmodule

// File: rtl/carry_column.sv
module carry_column #(
  parameter int SEGS = 4
) (
  input  logic [4*SEGS-1:0] op_a,
  input  logic [4*SEGS-1:0] op_b,
  input  logic              invert_b,
  input  logic              carry_init,
  output logic [4*SEGS-1:0] result,
  output logic              carry_out,
  output logic              overflow,
  output logic [SEGS-1:0]   seg_carry
);
  localparam int W = 4 * SEGS;

  logic [W-1:0]  b_eff;
  logic [W-1:0]  bit_carry;
  logic [SEGS:0] link;

  assign b_eff   = op_b ^ {W{invert_b}};
  assign link[0] = carry_init;

  for (genvar k = 0; k < SEGS; k++) begin : g_seg
    carry4_seg u_seg (
      .ci    (link[k]),
      .prop  (op_a[4*k+3:4*k] ^ b_eff[4*k+3:4*k]),
      .gen   (op_a[4*k+3:4*k]),
      .sum   (result[4*k+3:4*k]),
      .carry (bit_carry[4*k+3:4*k]),
      .co    (link[k+1])
    );
    assign seg_carry[k] = link[k+1];
  end

  assign carry_out = link[SEGS];
  assign overflow  = bit_carry[W-1] ^ bit_carry[W-2];

  logic [W:0] ref_sum;
  assign ref_sum = {1'b0, op_a} + {1'b0, b_eff} + {{W{1'b0}}, carry_init};

  always_comb begin
    AST_WORD_SUM: assert ({carry_out, result} == ref_sum)  // R4
      else $error("column sum mismatch");
    AST_OVERFLOW: assert (overflow == ((op_a[W-1] == b_eff[W-1]) && (result[W-1] != op_a[W-1])))  // R6
      else $error("overflow flag mismatch");
  end

  for (genvar k = 0; k < SEGS; k++) begin : g_chk
    localparam int LW = 4 * (k + 1);
    logic [LW:0] part;
    assign part = {1'b0, op_a[LW-1:0]} + {1'b0, b_eff[LW-1:0]} + {{LW{1'b0}}, carry_init};
    always_comb begin
      AST_SEG_BOUNDARY: assert (seg_carry[k] == part[LW])  // R3
        else $error("segment boundary carry mismatch");
    end
  end
endmodule

// File: tb/carry_column_tb.sv
module carry_column_tb;
  localparam int SEGS = 4;
  localparam int W = 4 * SEGS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0]    op_a, op_b, result;
  logic            invert_b, carry_init, carry_out, overflow;
  logic [SEGS-1:0] seg_carry;

  carry_column #(.SEGS(SEGS)) u_dut (
    .op_a(op_a), .op_b(op_b), .invert_b(invert_b), .carry_init(carry_init),
    .result(result), .carry_out(carry_out), .overflow(overflow), .seg_carry(seg_carry)
  );

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic logic [W:0] exp_sum(logic [W-1:0] a, logic [W-1:0] b, logic inv, logic ci);
    logic [W-1:0] be = inv ? ~b : b;
    return {1'b0, a} + {1'b0, be} + {{W{1'b0}}, ci};
  endfunction

  function automatic logic [SEGS-1:0] exp_seg(logic [W-1:0] a, logic [W-1:0] b, logic inv, logic ci);
    logic [W-1:0] be = inv ? ~b : b;
    logic [SEGS-1:0] r;
    for (int k = 0; k < SEGS; k++) begin
      logic [W:0] s = '0;
      for (int i = 0; i < 4 * (k + 1); i++) begin
        s[i] = 1'b1;
      end
      r[k] = ((({1'b0, a} & s) + ({1'b0, be} & s) + {{W{1'b0}}, ci}) >> (4 * (k + 1))) & 1;
    end
    return r;
  endfunction

  function automatic logic exp_ovf(logic [W-1:0] a, logic [W-1:0] b, logic inv, logic ci);
    logic [W-1:0] be = inv ? ~b : b;
    logic [W:0] s = exp_sum(a, b, inv, ci);
    return (a[W-1] == be[W-1]) && (s[W-1] != a[W-1]);
  endfunction

  task automatic check(string req, logic [W:0] act, logic [W:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic inv, logic ci, string req);
    logic [W:0] es;
    @(posedge clk);
    op_a = a; op_b = b; invert_b = inv; carry_init = ci;
    @(negedge clk);
    es = exp_sum(a, b, inv, ci);
    check(req, {carry_out, result}, es);
    check("R3", {{(W+1-SEGS){1'b0}}, seg_carry}, {{(W+1-SEGS){1'b0}}, exp_seg(a, b, inv, ci)});
    check("R6", {{W{1'b0}}, overflow}, {{W{1'b0}}, exp_ovf(a, b, inv, ci)});
  endtask

  initial begin
    op_a = '0; op_b = '0; invert_b = 1'b0; carry_init = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 reset state", {carry_out, result}, '0);

    // R1: carry entering bit 0 ripples to the top through propagating bits
    apply(16'h0001, 16'hFFFF, 1'b0, 1'b0, "R1");
    check("R1 ripple", {carry_out, result}, {1'b1, 16'h0000});
    // R2: sum is propagate xor carry-in
    apply(16'h5555, 16'hAAAA, 1'b0, 1'b0, "R2");
    check("R2 no carry", {carry_out, result}, {1'b0, 16'hFFFF});
    apply(16'h5555, 16'hAAAA, 1'b0, 1'b1, "R2");
    check("R2 carry in", {carry_out, result}, {1'b1, 16'h0000});
    // R7: all propagate, carry passes the column
    apply(16'hFFFF, 16'h0000, 1'b0, 1'b1, "R7");
    check("R7 seg", {{(W+1-SEGS){1'b0}}, seg_carry}, {{(W+1-SEGS){1'b0}}, 4'hF});
    apply(16'h1234, 16'h1234, 1'b1, 1'b0, "R7");
    check("R7 low", {carry_out, 12'h000, seg_carry}, '0);
    // R8: no propagate, carry_out = op_a msb
    apply(16'h8000, 16'h8000, 1'b0, 1'b1, "R8");
    check("R8 msb", {{W{1'b0}}, carry_out}, 17'd1);
    check("R8 ovf", {{W{1'b0}}, overflow}, 17'd1);
    apply(16'h7FFF, 16'h7FFF, 1'b0, 1'b1, "R8");
    check("R8 zero msb", {{W{1'b0}}, carry_out}, 17'd0);
    // R5: subtraction corners
    apply(16'h1234, 16'h1234, 1'b1, 1'b1, "R5");
    check("R5 equal", {carry_out, result}, {1'b1, 16'h0000});
    apply(16'h0003, 16'h0005, 1'b1, 1'b1, "R5");
    check("R5 borrow", {carry_out, result}, {1'b0, 16'hFFFE});
    apply(16'h8000, 16'h0001, 1'b1, 1'b1, "R5");
    check("R5 ovf", {{W{1'b0}}, overflow}, 17'd1);

    void'($urandom(32'd1234));
    for (int n = 0; n < 300; n++) begin
      logic [W-1:0] a = W'($urandom);
      logic [W-1:0] b = W'($urandom);
      if (n % 2 == 0) begin
        apply(a, b, 1'b0, 1'($urandom), "R4");
      end else begin
        apply(a, b, 1'b1, 1'b1, "R5");
        check("R5 diff", {1'b0, result}, {1'b0, a - b});
        check("R5 noborrow", {{W{1'b0}}, carry_out}, {{W{1'b0}}, (a >= b)});
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 200000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule